// File: doc/BRIEF.md
# UART Prioritized Interrupt Controller

This block collects every interrupt condition of a FIFO-based serial port and presents one of them at a time. It holds a pending flag for each edge- or event-driven source and takes the level-driven receive-ready condition straight from the FIFO level comparison. It masks these with the enable inputs and passes the result through a fixed-priority encoder. The encoder drives an active-high interrupt line and a 6-bit source code. The code carries a 1 in bit 0 when nothing is pending.

Each source has its own clearing event. Some clear on a register access strobe from the host side (status read, line read, modem read, GPIO read, receive-data read, transmit-data write). Others clear when the FIFO condition goes away, or when an Xon character arrives. The block also contains the receive idle timer. This timer counts bit-time ticks while the receive FIFO holds data. After four character frames plus twelve bit times without activity, it raises the timeout source.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The extended enables (`ext_en[0]` Xoff/special, `ext_en[1]` RTS, `ext_en[2]` CTS) have effect only while `ext_gate` is 1. With `ext_gate` at 0, the codes 6'h10 and 6'h20 are never reported.
- R2: With nothing enabled and pending, `irq` is 0 and `src_code` is 6'h01. After reset nothing is pending.
- R3: The line-status source (code 6'h06) is set by a pulse on any of `line_evt` bits 1, 2, 3, 4 or 7. Bits 0, 5 and 6 are ignored. It clears on `line_rd` only while `rx_err_left` is 0. Enable: `int_en[2]`.
- R4: Receive-ready (code 6'h04) follows the `rx_at_trig` level with no latching. Enable: `int_en[0]`.
- R5: The receive timeout (code 6'h0C) is set once the timer reaches 4*FRAME_BITS+12 `bit_tick` pulses. The timer restarts on `rx_char` or `rxdata_rd` and stays at zero while `rx_nonempty` is 0. A `rxdata_rd` clears the source. Enable: `int_en[0]`.
- R6: Transmit-ready (code 6'h02) is set on the rising edge of (`tx_empty` OR `tx_below_trig`). It clears on `txdata_wr`, or on `stat_rd` while 6'h02 is the reported code. A `stat_rd` leaves other sources untouched. Enable: `int_en[1]`.
- R7: Modem-status (code 6'h00) is set by any `modem_evt` pulse and cleared by `modem_rd`. GPIO (code 6'h30) is set when any `gpio_in` bit toggles and cleared by `gpio_rd`. Both are enabled by `int_en[3]`.
- R8: Xoff/special (code 6'h10) is set by `xoff_det` and cleared by `xon_det`.
- R9: Flow (code 6'h20) is set by a 0-to-1 edge of `cts_n` while `auto_cts` is 1, or by a 0-to-1 edge of `rts_n` while `auto_rts` is 1. The two edge sources are independent and each uses its own enable. `modem_rd` clears both.
- R10: The priority order, highest first, is line status, timeout, receive ready, transmit ready, modem, GPIO, Xoff, flow. Lower sources stay pending and show once the higher ones are cleared.
- R11: Pending flags latch whether or not their enable is set. A disabled source never drives `irq` or the code. Enabling it later exposes a flag that is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_en | input | 4 | Basic enables: rx data, tx, line, modem/GPIO |
| ext_en | input | 3 | Extended enables: Xoff, RTS, CTS |
| ext_gate | input | 1 | Gate that validates `ext_en` |
| line_evt | input | 8 | Line-status set pulses, one per bit |
| rx_err_left | input | 1 | Errored characters remain in the receive FIFO |
| rx_at_trig | input | 1 | Receive level at or above trigger |
| rx_nonempty | input | 1 | Receive FIFO holds data |
| rx_char | input | 1 | A character was received this cycle |
| bit_tick | input | 1 | One pulse per bit time |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_below_trig | input | 1 | Transmit level at or below trigger |
| modem_evt | input | 4 | Modem-status change pulses |
| gpio_in | input | GPIO_W | GPIO input levels |
| xoff_det | input | 1 | Xoff/special character matched |
| xon_det | input | 1 | Xon character received |
| cts_n | input | 1 | CTS line level |
| auto_cts | input | 1 | Automatic CTS flow control active |
| rts_n | input | 1 | RTS line level as driven |
| auto_rts | input | 1 | Automatic RTS flow control active |
| stat_rd | input | 1 | Status register read strobe |
| line_rd | input | 1 | Line-status read strobe |
| modem_rd | input | 1 | Modem-status read strobe |
| gpio_rd | input | 1 | GPIO state read strobe |
| rxdata_rd | input | 1 | Receive data read strobe |
| txdata_wr | input | 1 | Transmit data write strobe |
| irq | output | 1 | Interrupt active |
| src_code | output | 6 | Code of the reported source |

## Verification
The assertions assume that the strobe inputs are single-cycle pulses sampled at the rising edge. They also assume that `xon_det` and `xoff_det` are never raised in the same cycle, and that FRAME_BITS makes the timeout long enough that a receive-data read cannot be followed by a new expiry on the next cycle. The bench drives every input on the falling edge and drops each strobe after exactly one rising edge. It never raises Xon and Xoff together, and it lets the timer run only from a known restart. This makes the expiry cycle exact.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NSLOT = 8;

    localparam logic [5:0] CODE_NONE = 6'h01;
    localparam logic [5:0] CODE_LS   = 6'h06;
    localparam logic [5:0] CODE_TMO  = 6'h0C;
    localparam logic [5:0] CODE_RX   = 6'h04;
    localparam logic [5:0] CODE_TX   = 6'h02;
    localparam logic [5:0] CODE_MS   = 6'h00;
    localparam logic [5:0] CODE_GPIO = 6'h30;
    localparam logic [5:0] CODE_XOFF = 6'h10;
    localparam logic [5:0] CODE_FLOW = 6'h20;

    // line-status bits that may raise the source
    localparam logic [7:0] LINE_MASK = 8'b1001_1110;

    // slot index = priority, 0 highest
    typedef enum logic [2:0] {
        SL_LS, SL_TMO, SL_RX, SL_TX, SL_MS, SL_GPIO, SL_XOFF, SL_FLOW
    } slot_e;

    typedef struct packed {
        logic ls;
        logic tmo;
        logic tx;
        logic ms;
        logic gpio;
        logic xoff;
        logic cts;
        logic rts;
    } pend_t;

    function automatic logic [5:0] slot_code(input int s);
        case (s)
            0:       return CODE_LS;
            1:       return CODE_TMO;
            2:       return CODE_RX;
            3:       return CODE_TX;
            4:       return CODE_MS;
            5:       return CODE_GPIO;
            6:       return CODE_XOFF;
            default: return CODE_FLOW;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_edge.sv
module uart_irq_edge #(
    parameter int W        = 1,
    parameter bit TOGGLE   = 1'b0,
    parameter bit RST_HIGH = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] evt
);
    logic [W-1:0] prev_d, prev_q;

    always_comb prev_d = sig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_HIGH ? {W{1'b1}} : {W{1'b0}};
        else        prev_q <= prev_d;
    end

    generate
        if (TOGGLE) begin : g_toggle
            assign evt = sig ^ prev_q;
        end else begin : g_rise
            assign evt = sig & ~prev_q;
        end
    endgenerate
endmodule

// File: rtl/uart_irq_tmo.sv
module uart_irq_tmo #(
    parameter int FRAME_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic rx_nonempty,
    input  logic restart,
    output logic expire
);
    localparam int LIMIT = 4 * FRAME_BITS + 12;
    localparam int CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_C  = CW'(LIMIT);
    localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (!rx_nonempty || restart) begin
            cnt_d = '0;
        end else if (bit_tick && (cnt_q < LIM_C)) begin
            cnt_d  = cnt_q + 1'b1;
            expire = (cnt_q == LIM_M1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_slot
            if (i == 0) begin : g_top
                assign grant[i] = req[i];
            end else begin : g_low
                assign grant[i] = req[i] & ~(|req[i-1:0]);
            end
        end
    endgenerate

    assign any = |req;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int FRAME_BITS = 10,
    parameter int GPIO_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        int_en,
    input  logic [2:0]        ext_en,
    input  logic              ext_gate,
    input  logic [7:0]        line_evt,
    input  logic              rx_err_left,
    input  logic              rx_at_trig,
    input  logic              rx_nonempty,
    input  logic              rx_char,
    input  logic              bit_tick,
    input  logic              tx_empty,
    input  logic              tx_below_trig,
    input  logic [3:0]        modem_evt,
    input  logic [GPIO_W-1:0] gpio_in,
    input  logic              xoff_det,
    input  logic              xon_det,
    input  logic              cts_n,
    input  logic              auto_cts,
    input  logic              rts_n,
    input  logic              auto_rts,
    input  logic              stat_rd,
    input  logic              line_rd,
    input  logic              modem_rd,
    input  logic              gpio_rd,
    input  logic              rxdata_rd,
    input  logic              txdata_wr,
    output logic              irq,
    output logic [5:0]        src_code
);
    pend_t pend_d, pend_q;

    logic              tmo_expire;
    logic              tx_cond, tx_rise;
    logic [GPIO_W-1:0] gpio_tog;
    logic              cts_rise, rts_rise;
    logic [2:0]        xen;
    logic [NSLOT-1:0]  req, grant;
    logic              any_req;
    logic [5:0]        code_or;

    uart_irq_tmo #(.FRAME_BITS(FRAME_BITS)) u_tmo (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .rx_nonempty (rx_nonempty),
        .restart     (rx_char | rxdata_rd),
        .expire      (tmo_expire)
    );

    assign tx_cond = tx_empty | tx_below_trig;

    uart_irq_edge #(.W(1), .TOGGLE(1'b0), .RST_HIGH(1'b0)) u_tx_edge (
        .clk (clk), .rst_n (rst_n), .sig (tx_cond), .evt (tx_rise)
    );

    uart_irq_edge #(.W(GPIO_W), .TOGGLE(1'b1), .RST_HIGH(1'b0)) u_gpio_edge (
        .clk (clk), .rst_n (rst_n), .sig (gpio_in), .evt (gpio_tog)
    );

    uart_irq_edge #(.W(1), .TOGGLE(1'b0), .RST_HIGH(1'b1)) u_cts_edge (
        .clk (clk), .rst_n (rst_n), .sig (cts_n), .evt (cts_rise)
    );

    uart_irq_edge #(.W(1), .TOGGLE(1'b0), .RST_HIGH(1'b1)) u_rts_edge (
        .clk (clk), .rst_n (rst_n), .sig (rts_n), .evt (rts_rise)
    );

    // extended enables count only behind the gate
    assign xen = ext_gate ? ext_en : 3'b000;

    always_comb begin
        req                = '0;
        req[int'(SL_LS)]   = pend_q.ls   & int_en[2];
        req[int'(SL_TMO)]  = pend_q.tmo  & int_en[0];
        req[int'(SL_RX)]   = rx_at_trig  & int_en[0];
        req[int'(SL_TX)]   = pend_q.tx   & int_en[1];
        req[int'(SL_MS)]   = pend_q.ms   & int_en[3];
        req[int'(SL_GPIO)] = pend_q.gpio & int_en[3];
        req[int'(SL_XOFF)] = pend_q.xoff & xen[0];
        req[int'(SL_FLOW)] = (pend_q.rts & xen[1]) | (pend_q.cts & xen[2]);
    end

    uart_irq_prio #(.N(NSLOT)) u_prio (
        .req   (req),
        .grant (grant),
        .any   (any_req)
    );

    always_comb begin
        code_or = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (grant[i]) code_or = code_or | slot_code(i);
        end
    end

    assign irq      = any_req;
    assign src_code = any_req ? code_or : CODE_NONE;

    // next-state: clears first, sets override
    always_comb begin
        pend_d = pend_q;

        if (line_rd && !rx_err_left) pend_d.ls = 1'b0;
        if (|(line_evt & LINE_MASK)) pend_d.ls = 1'b1;

        if (rxdata_rd)  pend_d.tmo = 1'b0;
        if (tmo_expire) pend_d.tmo = 1'b1;

        if (txdata_wr || (stat_rd && grant[int'(SL_TX)])) pend_d.tx = 1'b0;
        if (tx_rise) pend_d.tx = 1'b1;

        if (modem_rd) begin
            pend_d.ms  = 1'b0;
            pend_d.cts = 1'b0;
            pend_d.rts = 1'b0;
        end
        if (|modem_evt)            pend_d.ms  = 1'b1;
        if (cts_rise && auto_cts)  pend_d.cts = 1'b1;
        if (rts_rise && auto_rts)  pend_d.rts = 1'b1;

        if (gpio_rd)    pend_d.gpio = 1'b0;
        if (|gpio_tog)  pend_d.gpio = 1'b1;

        if (xon_det)  pend_d.xoff = 1'b0;
        if (xoff_det) pend_d.xoff = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk
    import uart_irq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] int_en,
    input logic       ext_gate,
    input logic       rx_at_trig,
    input logic       rxdata_rd,
    input logic       xon_det,
    input logic       xoff_det,
    input logic       irq,
    input logic [5:0] src_code
);
    a_r1_gate_blocks_ext: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_gate |-> (src_code != CODE_XOFF && src_code != CODE_FLOW));

    a_r2_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> src_code == CODE_NONE);

    a_r4_level_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_at_trig && int_en[0]) |-> irq);

    a_r5_read_drops_tmo: assert property (@(posedge clk) disable iff (!rst_n)
        rxdata_rd |=> src_code != CODE_TMO);

    a_r6_tx_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        src_code == CODE_TX |-> int_en[1]);

    a_r8_xon_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (xon_det && !xoff_det) |=> src_code != CODE_XOFF);

    a_r11_masked_modem: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en[3] |-> (src_code != CODE_MS && src_code != CODE_GPIO) || !irq);
endmodule

bind uart_irq_ctrl uart_irq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_en     (int_en),
    .ext_gate   (ext_gate),
    .rx_at_trig (rx_at_trig),
    .rxdata_rd  (rxdata_rd),
    .xon_det    (xon_det),
    .xoff_det   (xoff_det),
    .irq        (irq),
    .src_code   (src_code)
);

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
    localparam int GW = 8;
    localparam logic [5:0] C_NONE = 6'h01, C_LS = 6'h06, C_TMO = 6'h0C,
        C_RX = 6'h04, C_TX = 6'h02, C_MS = 6'h00, C_GPIO = 6'h30,
        C_XOFF = 6'h10, C_FLOW = 6'h20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [3:0] int_en = '0;
    logic [2:0] ext_en = '0;
    logic ext_gate = 0, rx_err_left = 0, rx_at_trig = 0, rx_nonempty = 0;
    logic rx_char = 0, bit_tick = 0, tx_empty = 0, tx_below_trig = 0;
    logic [7:0] line_evt = '0;
    logic [3:0] modem_evt = '0;
    logic [GW-1:0] gpio_in = '0;
    logic xoff_det = 0, xon_det = 0, cts_n = 1, auto_cts = 0, rts_n = 1, auto_rts = 0;
    logic stat_rd = 0, line_rd = 0, modem_rd = 0, gpio_rd = 0, rxdata_rd = 0, txdata_wr = 0;
    logic irq;
    logic [5:0] src_code;
    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_irq_ctrl #(.FRAME_BITS(10), .GPIO_W(GW)) u_dut (.*);

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [5:0] exp_code);
        logic exp_irq;
        exp_irq = (exp_code != C_NONE);
        n_checks++;
        if (src_code !== exp_code || irq !== exp_irq) begin
            n_fail++;
            $display("FAIL %s: code=%h irq=%b expected code=%h irq=%b",
                     req, src_code, irq, exp_code, exp_irq);
        end
    endtask

    task automatic t_reset();
        chk("R2 reset", C_NONE);
    endtask

    task automatic t_gate();
        ext_en = 3'b111; ext_gate = 0;
        xoff_det = 1; step(); xoff_det = 0;
        chk("R1 gate closed", C_NONE);
        ext_gate = 1; #1;
        chk("R11 latched while blocked", C_XOFF);
        xon_det = 1; step(); xon_det = 0;
        chk("R8 xon clears", C_NONE);
        ext_en = '0; ext_gate = 0;
    endtask

    task automatic t_line();
        int_en = 4'b0100;
        line_evt = 8'h61; step(); line_evt = '0;
        chk("R3 masked bits ignored", C_NONE);
        line_evt = 8'h80; step(); line_evt = '0;
        chk("R3 bit7 sets", C_LS);
        rx_err_left = 1; line_rd = 1; step(); line_rd = 0;
        chk("R3 errors left", C_LS);
        rx_err_left = 0; line_rd = 1; step(); line_rd = 0;
        chk("R3 cleared", C_NONE);
        int_en = '0;
    endtask

    task automatic t_rx();
        int_en = 4'b0001;
        rx_at_trig = 1; #1; chk("R4 at trigger", C_RX);
        rx_at_trig = 0; #1; chk("R4 below trigger", C_NONE);
        int_en = '0;
    endtask

    task automatic t_tmo();
        int_en = 4'b0001; bit_tick = 1;
        repeat (100) step();
        chk("R5 idle while empty", C_NONE);
        rx_nonempty = 1; rx_char = 1; step(); rx_char = 0;
        repeat (51) step();
        chk("R5 one tick early", C_NONE);
        step();
        chk("R5 expiry", C_TMO);
        rxdata_rd = 1; step(); rxdata_rd = 0;
        chk("R5 read clears", C_NONE);
        repeat (30) step();
        rxdata_rd = 1; step(); rxdata_rd = 0;
        repeat (51) step();
        chk("R5 read restarts", C_NONE);
        step();
        chk("R5 second expiry", C_TMO);
        rxdata_rd = 1; step(); rxdata_rd = 0;
        rx_nonempty = 0; bit_tick = 0;
        int_en = '0;
    endtask

    task automatic t_tx();
        int_en = 4'b0010;
        tx_empty = 1; step();
        chk("R6 empty edge", C_TX);
        stat_rd = 1; step(); stat_rd = 0;
        chk("R6 status read clears", C_NONE);
        tx_empty = 0; step();
        tx_below_trig = 1; step();
        chk("R6 trigger edge", C_TX);
        txdata_wr = 1; step(); txdata_wr = 0;
        chk("R6 write clears", C_NONE);
        tx_below_trig = 0; step();
        int_en = '0;
    endtask

    task automatic t_modem();
        int_en = 4'b1000;
        modem_evt = 4'b0100; step(); modem_evt = '0;
        chk("R7 modem event", C_MS);
        modem_rd = 1; step(); modem_rd = 0;
        chk("R7 modem read", C_NONE);
        gpio_in = gpio_in ^ 8'h08; step();
        chk("R7 gpio toggle", C_GPIO);
        gpio_rd = 1; step(); gpio_rd = 0;
        chk("R7 gpio read", C_NONE);
        int_en = '0;
    endtask

    task automatic t_flow();
        ext_gate = 1; ext_en = 3'b100; auto_cts = 1;
        cts_n = 0; step(); cts_n = 1; step();
        chk("R9 cts edge", C_FLOW);
        modem_rd = 1; step(); modem_rd = 0;
        chk("R9 modem read clears", C_NONE);
        auto_cts = 0; cts_n = 0; step(); cts_n = 1; step();
        chk("R9 no auto mode", C_NONE);
        auto_rts = 1; rts_n = 0; step(); rts_n = 1; step();
        chk("R11 rts disabled", C_NONE);
        ext_en = 3'b010; #1;
        chk("R9 rts shown once enabled", C_FLOW);
        modem_rd = 1; step(); modem_rd = 0;
        chk("R9 rts cleared", C_NONE);
        auto_rts = 0; ext_en = '0; ext_gate = 0;
    endtask

    task automatic t_prio();
        ext_gate = 1; ext_en = 3'b111; int_en = 4'b1111;
        line_evt = 8'h02; modem_evt = 4'b0001; xoff_det = 1;
        gpio_in = gpio_in ^ 8'h01; rx_at_trig = 1;
        step();
        line_evt = '0; modem_evt = '0; xoff_det = 0;
        chk("R10 line first", C_LS);
        line_rd = 1; step(); line_rd = 0;
        chk("R10 rx next", C_RX);
        rx_at_trig = 0; #1;
        chk("R10 modem next", C_MS);
        stat_rd = 1; step(); stat_rd = 0;
        chk("R6 status read spares modem", C_MS);
        modem_rd = 1; step(); modem_rd = 0;
        chk("R10 gpio next", C_GPIO);
        gpio_rd = 1; step(); gpio_rd = 0;
        chk("R10 xoff next", C_XOFF);
        xon_det = 1; step(); xon_det = 0;
        chk("R10 all clear", C_NONE);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_gate();
        t_line();
        t_rx();
        t_tmo();
        t_tx();
        t_modem();
        t_flow();
        t_prio();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run incomplete, expected completion");
            summary();
            $finish;
        end
    end
endmodule